// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Gate Lookup

This block is the microsequencer that turns an interrupt into a change of control flow in a simple 32-bit processor model. At an instruction boundary it accepts a non-maskable request, or a maskable request when the interrupt-enable flag is set. It computes the address of the 8-byte gate for the request's vector, reads the gate in two 32-bit words, and checks that the gate is valid. It then pushes the return state onto the stack and hands the core a new flags word, code selector, entry offset and stack pointer in one load strobe.

A return request runs the matching sequence. It pops the saved state from the stack in reverse order and loads it back. The memory port is a word-wide request/acknowledge port, and each access waits for its acknowledge. While a sequence runs the block reports busy and accepts nothing new. A gate that fails the check raises a one-cycle fault. The stack is then untouched and no state is loaded.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable request (irq_req) is accepted only when flags_in bit 9 (interrupt enable) is 1. While that bit is 0 the request is ignored: busy stays low, there is no memory access and no state load.
- R2: A non-maskable request (irq_nmi) is accepted regardless of flags_in bit 9. It uses vector 2 and takes priority over a maskable request presented in the same cycle.
- R3: No request of any kind is accepted in a cycle where insn_done is 0.
- R4: The gate address is tbl_base + 8 × vector. The word at that address is read first: entry offset bits 15..0 in bits 15..0 and the selector in bits 31..16. The word at address + 4 is read next: the dword count in bits 4..0, zero bits in 7..5, type in 11..8, DT in 12, DPL in 14..13, P in 15, and entry offset bits 31..16 in bits 31..16.
- R5: On a valid gate the block writes three words in this order. First the captured flags at sp_in−4, then the captured selector zero-extended to 32 bits at sp_in−8, then the captured instruction pointer at sp_in−12. Every access is word aligned.
- R6: After the pushes, state_we pulses for exactly one cycle with these values: ip_out = the gate's 32-bit entry offset, cs_out = the gate's selector, flags_out = the captured flags with bit 9 cleared, and sp_out = sp_in−12.
- R7: A gate is valid only with P=1, type 0xE, DT=0, DPL=0 and dword count 0 (and zero bits 7..5). Any other gate gives a one-cycle fault pulse after the two reads, with no stack write and no state_we.
- R8: A return request (iret_req, taken when no interrupt is taken) reads the instruction pointer at sp_in, the selector at sp_in+4 and the flags at sp_in+8. It then pulses state_we with those values unchanged and sp_out = sp_in+12.
- R9: busy rises in the cycle after acceptance and stays high up to and including the cycle of state_we or fault. No request is accepted while busy is high.
- R10: After reset busy, fault, state_we and mem_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction has completed (boundary) |
| irq_req | input | 1 | Maskable interrupt request |
| irq_vec | input | 8 | Vector of the maskable request |
| irq_nmi | input | 1 | Non-maskable interrupt request |
| iret_req | input | 1 | Return-from-interrupt request |
| flags_in | input | 32 | Current flags word |
| cs_in | input | 16 | Current code selector |
| ip_in | input | 32 | Current instruction pointer |
| sp_in | input | 32 | Current stack pointer |
| tbl_base | input | 32 | Byte address of the vector table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory access complete |
| busy | output | 1 | A sequence is in progress |
| fault | output | 1 | One-cycle pulse: gate rejected |
| state_we | output | 1 | One-cycle pulse: load the four state outputs |
| flags_out | output | 32 | New flags value |
| cs_out | output | 16 | New code selector |
| ip_out | output | 32 | New instruction pointer |
| sp_out | output | 32 | New stack pointer |

## Verification
The bound checker watches the handshake shape on every cycle. It checks that acceptance only follows an instruction boundary and, for maskable requests, a set enable flag. It checks that busy covers every load and fault, that fault and load never coincide, that the load pulse ends the sequence, and that the idle block never touches memory. The data side can only be shown by the bench's scenarios: the gate address arithmetic, the split entry offset, the push order, the saved values and the restored state after a return. The same holds for NMI priority and for the rejection of each kind of malformed gate.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_DLO,
      SQ_DHI,
      SQ_CHK,
      SQ_PFL,
      SQ_PCS,
      SQ_PIP,
      SQ_LOAD,
      SQ_FAULT,
      SQ_RIP,
      SQ_RCS,
      SQ_RFL,
      SQ_RLOAD
   } seq_state_t;

   localparam logic [3:0] GATE_KIND_INT = 4'hE;

endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
   parameter int VEC_W   = 8,
   parameter int NMI_VEC = 2
) (
   input  logic             idle,
   input  logic             boundary,
   input  logic             irq_req,
   input  logic             irq_nmi,
   input  logic             iret_req,
   input  logic             if_set,
   input  logic [VEC_W-1:0] irq_vec,
   output logic             take_int,
   output logic             take_ret,
   output logic [VEC_W-1:0] vec
);
   logic open_w;
   logic mask_ok;

   assign open_w   = idle && boundary;
   assign mask_ok  = irq_req && if_set;
   // non-maskable first, then maskable, then return
   assign take_int = open_w && (irq_nmi || mask_ok);
   assign take_ret = open_w && iret_req && !irq_nmi && !mask_ok;
   assign vec      = irq_nmi ? VEC_W'(NMI_VEC) : irq_vec;
endmodule

// File: rtl/irq_gate_decode.sv
module irq_gate_decode
   import irq_seq_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SEL_W  = 16,
   parameter bit STRICT = 1'b1
) (
   input  logic [WORD_W-1:0] lo_word,
   input  logic [WORD_W-1:0] hi_word,
   output logic [WORD_W-1:0] entry,
   output logic [SEL_W-1:0]  sel,
   output logic              ok
);
   localparam int HALF = WORD_W / 2;

   logic [4:0] cnt;
   logic [2:0] zbits;
   logic [3:0] kind;
   logic       dt;
   logic [1:0] dpl;
   logic       present;
   logic       core_ok;
   logic       extra_ok;

   assign entry    = {hi_word[WORD_W-1:HALF], lo_word[HALF-1:0]};
   assign sel      = lo_word[HALF +: SEL_W];
   assign cnt      = hi_word[4:0];
   assign zbits    = hi_word[7:5];
   assign kind     = hi_word[11:8];
   assign dt       = hi_word[12];
   assign dpl      = hi_word[14:13];
   assign present  = hi_word[15];
   assign core_ok  = present && (kind == GATE_KIND_INT);
   assign extra_ok = !dt && (dpl == 2'd0) && (cnt == 5'd0) && (zbits == 3'd0);

   generate
      if (STRICT) begin : g_strict
         assign ok = core_ok && extra_ok;
      end else begin : g_loose
         logic unused_extra;
         assign unused_extra = extra_ok;
         assign ok = core_ok;
      end
   endgenerate
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int SEL_W       = 16,
   parameter int VEC_W       = 8,
   parameter int IF_BIT      = 9,
   parameter int NMI_VEC     = 2,
   parameter bit STRICT_GATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             insn_done,
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             irq_nmi,
   input  logic             iret_req,
   input  logic [XLEN-1:0]  flags_in,
   input  logic [SEL_W-1:0] cs_in,
   input  logic [XLEN-1:0]  ip_in,
   input  logic [XLEN-1:0]  sp_in,
   input  logic [XLEN-1:0]  tbl_base,
   output logic             mem_req,
   output logic             mem_we,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic [XLEN-1:0]  mem_rdata,
   input  logic             mem_ack,
   output logic             busy,
   output logic             fault,
   output logic             state_we,
   output logic [XLEN-1:0]  flags_out,
   output logic [SEL_W-1:0] cs_out,
   output logic [XLEN-1:0]  ip_out,
   output logic [XLEN-1:0]  sp_out
);
   localparam int              WORD_BYTES = XLEN / 8;
   localparam int              GATE_BYTES = 2 * WORD_BYTES;
   localparam int              GATE_SH    = $clog2(GATE_BYTES);
   localparam logic [XLEN-1:0] STEP       = XLEN'(WORD_BYTES);
   localparam logic [XLEN-1:0] IF_MASK    = XLEN'(1) << IF_BIT;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("irq_entry_seq: gate layout needs a 32-bit word");
      end
      if (SEL_W != XLEN / 2) begin : g_bad_sel
         $error("irq_entry_seq: selector must fill half a word");
      end
      if (IF_BIT >= XLEN) begin : g_bad_if
         $error("irq_entry_seq: enable bit outside flags word");
      end
      if (NMI_VEC >= (1 << VEC_W)) begin : g_bad_nmi
         $error("irq_entry_seq: NMI vector does not fit");
      end
   endgenerate

   seq_state_t       state;
   logic [XLEN-1:0]  desc_addr;
   logic [XLEN-1:0]  lo_r;
   logic [XLEN-1:0]  hi_r;
   logic [XLEN-1:0]  flags_r;
   logic [SEL_W-1:0] cs_r;
   logic [XLEN-1:0]  ip_r;
   logic [XLEN-1:0]  sp_r;

   logic             take_int;
   logic             take_ret;
   logic [VEC_W-1:0] vec_sel;
   logic [XLEN-1:0]  gate_entry;
   logic [SEL_W-1:0] gate_sel;
   logic             gate_ok;

   irq_accept #(
      .VEC_W  (VEC_W),
      .NMI_VEC(NMI_VEC)
   ) u_accept (
      .idle    (state == SQ_IDLE),
      .boundary(insn_done),
      .irq_req (irq_req),
      .irq_nmi (irq_nmi),
      .iret_req(iret_req),
      .if_set  (flags_in[IF_BIT]),
      .irq_vec (irq_vec),
      .take_int(take_int),
      .take_ret(take_ret),
      .vec     (vec_sel)
   );

   irq_gate_decode #(
      .WORD_W(XLEN),
      .SEL_W (SEL_W),
      .STRICT(STRICT_GATE)
   ) u_decode (
      .lo_word(lo_r),
      .hi_word(hi_r),
      .entry  (gate_entry),
      .sel    (gate_sel),
      .ok     (gate_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         desc_addr <= '0;
         lo_r      <= '0;
         hi_r      <= '0;
         flags_r   <= '0;
         cs_r      <= '0;
         ip_r      <= '0;
         sp_r      <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (take_int) begin
                  desc_addr <= tbl_base + (XLEN'(vec_sel) << GATE_SH);
                  flags_r   <= flags_in;
                  cs_r      <= cs_in;
                  ip_r      <= ip_in;
                  sp_r      <= sp_in;
                  state     <= SQ_DLO;
               end else if (take_ret) begin
                  sp_r  <= sp_in;
                  state <= SQ_RIP;
               end
            end
            SQ_DLO: if (mem_ack) begin
               lo_r  <= mem_rdata;
               state <= SQ_DHI;
            end
            SQ_DHI: if (mem_ack) begin
               hi_r  <= mem_rdata;
               state <= SQ_CHK;
            end
            SQ_CHK:   state <= gate_ok ? SQ_PFL : SQ_FAULT;
            SQ_PFL: if (mem_ack) begin
               sp_r  <= sp_r - STEP;
               state <= SQ_PCS;
            end
            SQ_PCS: if (mem_ack) begin
               sp_r  <= sp_r - STEP;
               state <= SQ_PIP;
            end
            SQ_PIP: if (mem_ack) begin
               sp_r  <= sp_r - STEP;
               state <= SQ_LOAD;
            end
            SQ_RIP: if (mem_ack) begin
               ip_r  <= mem_rdata;
               sp_r  <= sp_r + STEP;
               state <= SQ_RCS;
            end
            SQ_RCS: if (mem_ack) begin
               cs_r  <= mem_rdata[SEL_W-1:0];
               sp_r  <= sp_r + STEP;
               state <= SQ_RFL;
            end
            SQ_RFL: if (mem_ack) begin
               flags_r <= mem_rdata;
               sp_r    <= sp_r + STEP;
               state   <= SQ_RLOAD;
            end
            default:  state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         SQ_DLO: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr;
         end
         SQ_DHI: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + STEP;
         end
         SQ_PFL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_r - STEP;
            mem_wdata = flags_r;
         end
         SQ_PCS: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_r - STEP;
            mem_wdata = XLEN'(cs_r);
         end
         SQ_PIP: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_r - STEP;
            mem_wdata = ip_r;
         end
         SQ_RIP, SQ_RCS, SQ_RFL: begin
            mem_req  = 1'b1;
            mem_addr = sp_r;
         end
         default: ;
      endcase
   end

   assign busy      = (state != SQ_IDLE);
   assign fault     = (state == SQ_FAULT);
   assign state_we  = (state == SQ_LOAD) || (state == SQ_RLOAD);
   assign flags_out = (state == SQ_LOAD) ? (flags_r & ~IF_MASK) : flags_r;
   assign cs_out    = (state == SQ_LOAD) ? gate_sel : cs_r;
   assign ip_out    = (state == SQ_LOAD) ? gate_entry : ip_r;
   assign sp_out    = sp_r;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       insn_done,
   input logic       irq_nmi,
   input logic       iret_req,
   input logic       flags_if,
   input logic       mem_req,
   input logic [1:0] mem_addr_lo,
   input logic       state_we,
   input logic       fault
);
   // R1
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !$past(irq_nmi) && !$past(iret_req)) |-> $past(flags_if));
   // R3
   boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_done));
   // R5
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr_lo == 2'b00));
   // R6
   load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_we |=> !busy);
   // R7
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!state_we && !mem_req));
   // R9
   load_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_we || fault) |-> busy);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !state_we && !fault) |=> busy);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .insn_done  (insn_done),
   .irq_nmi    (irq_nmi),
   .iret_req   (iret_req),
   .flags_if   (flags_in[IF_BIT]),
   .mem_req    (mem_req),
   .mem_addr_lo(mem_addr[1:0]),
   .state_we   (state_we),
   .fault      (fault)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] TBL = 32'h0000_0100;
   localparam logic [31:0] IFM = 32'h0000_0200;

   localparam int K_RD = 0;
   localparam int K_WR = 1;
   localparam int K_LD = 2;
   localparam int K_FT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_done = 1'b0;
   logic        irq_req = 1'b0;
   logic [7:0]  irq_vec = '0;
   logic        irq_nmi = 1'b0;
   logic        iret_req = 1'b0;
   logic [31:0] flags_in = '0;
   logic [15:0] cs_in = '0;
   logic [31:0] ip_in = '0;
   logic [31:0] sp_in = '0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        busy, fault, state_we;
   logic [31:0] flags_out, ip_out, sp_out;
   logic [15:0] cs_out;

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_nmi(irq_nmi),
      .iret_req(iret_req), .flags_in(flags_in), .cs_in(cs_in),
      .ip_in(ip_in), .sp_in(sp_in), .tbl_base(TBL),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .busy(busy), .fault(fault), .state_we(state_we),
      .flags_out(flags_out), .cs_out(cs_out), .ip_out(ip_out),
      .sp_out(sp_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [31:0] mem [0:1023];
   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[11:2]];
   always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;

   typedef struct {
      int          kind;
      logic [31:0] a, b, c, d;
      string       tag;
   } ev_t;

   ev_t q[$];
   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;

   task automatic push_ev(int kind, logic [31:0] a, logic [31:0] b,
                          logic [31:0] c, logic [31:0] d, string tag);
      ev_t e;
      e.kind = kind; e.a = a; e.b = b; e.c = c; e.d = d; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic check(bit ok, string tag, string what,
                        logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic cmp(int kind, logic [31:0] a, logic [31:0] b,
                      logic [31:0] c, logic [31:0] d);
      ev_t e;
      if (q.size() == 0) begin
         check(0, "R9", "unexpected event kind", 32'(kind), 32'hFFFF_FFFF);
         return;
      end
      e = q.pop_front();
      check(e.kind == kind, e.tag, "event kind", 32'(kind), 32'(e.kind));
      check(e.a == a, e.tag, "field a", a, e.a);
      check(e.b == b, e.tag, "field b", b, e.b);
      check(e.c == c, e.tag, "field c", c, e.c);
      check(e.d == d, e.tag, "field d", d, e.d);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mem_req && !mem_we) cmp(K_RD, mem_addr, 0, 0, 0);
         if (mem_req && mem_we)  cmp(K_WR, mem_addr, mem_wdata, 0, 0);
         if (state_we)           cmp(K_LD, ip_out, {16'h0, cs_out}, flags_out, sp_out);
         if (fault)              cmp(K_FT, 0, 0, 0, 0);
      end
   end

   task automatic put_gate(int vec, logic [31:0] off, logic [15:0] sel, logic p,
                           logic [1:0] dpl, logic dt, logic [3:0] typ, logic [4:0] cnt);
      logic [31:0] ad;
      ad = TBL + 32'(vec) * 8;
      mem[ad[11:2]]       = {sel, off[15:0]};
      mem[ad[11:2] + 1]   = {off[31:16], p, dpl, dt, typ, 3'b000, cnt};
   endtask

   // driver: expected entry events
   task automatic exp_entry(int vec, bit ok, logic [31:0] off, logic [15:0] sel);
      logic [31:0] ad;
      ad = TBL + 32'(vec) * 8;
      push_ev(K_RD, ad, 0, 0, 0, "R4");
      push_ev(K_RD, ad + 4, 0, 0, 0, "R4");
      if (ok) begin
         push_ev(K_WR, sp_in - 4,  flags_in, 0, 0, "R5");
         push_ev(K_WR, sp_in - 8,  {16'h0, cs_in}, 0, 0, "R5");
         push_ev(K_WR, sp_in - 12, ip_in, 0, 0, "R5");
         push_ev(K_LD, off, {16'h0, sel}, flags_in & ~IFM, sp_in - 12, "R6");
      end else begin
         push_ev(K_FT, 0, 0, 0, 0, "R7");
      end
   endtask

   task automatic drain(string tag);
      int n = 0;
      while ((q.size() != 0 || busy) && n < 60) begin
         @(negedge clk);
         n++;
      end
      check(q.size() == 0 && !busy, tag, "sequence drained", 32'(q.size()), 0);
   endtask

   task automatic fire_irq(logic [7:0] v, bit nmi);
      irq_vec = v; irq_req = !nmi; irq_nmi = nmi; insn_done = 1'b1;
      @(negedge clk);
      check(busy == 1'b1, "R9", "busy after accept", 32'(busy), 1);
      irq_req = 1'b0; irq_nmi = 1'b0; insn_done = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      put_gate(8'h21, 32'hCAFE_1234, 16'h0008, 1, 0, 0, 4'hE, 0);
      put_gate(2,     32'h0001_0200, 16'h0010, 1, 0, 0, 4'hE, 0);
      put_gate(8'hFF, 32'hFFFF_0004, 16'h0018, 1, 0, 0, 4'hE, 0);
      put_gate(8'h40, 32'h0000_4000, 16'h0008, 0, 0, 0, 4'hE, 0);
      put_gate(8'h41, 32'h0000_4100, 16'h0008, 1, 0, 0, 4'hF, 0);
      put_gate(8'h42, 32'h0000_4200, 16'h0008, 1, 3, 0, 4'hE, 0);
      put_gate(8'h43, 32'h0000_4300, 16'h0008, 1, 0, 0, 4'hE, 5'd4);

      repeat (3) @(negedge clk);
      // R10 reset state
      check(busy == 0,     "R10", "busy in reset", 32'(busy), 0);
      check(mem_req == 0,  "R10", "mem_req in reset", 32'(mem_req), 0);
      check(state_we == 0, "R10", "state_we in reset", 32'(state_we), 0);
      check(fault == 0,    "R10", "fault in reset", 32'(fault), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 maskable ignored with enable clear
      flags_in = 32'h0000_0046; cs_in = 16'h0020; ip_in = 32'h0000_8000; sp_in = 32'h0000_0E00;
      irq_vec = 8'h21; irq_req = 1; insn_done = 1;
      repeat (6) begin
         @(negedge clk);
         check(busy == 0, "R1", "masked request ignored", 32'(busy), 0);
      end
      irq_req = 0; insn_done = 0;

      // R3 no acceptance without boundary
      flags_in = 32'h0000_0246; irq_req = 1;
      repeat (5) begin
         @(negedge clk);
         check(busy == 0, "R3", "waits for boundary", 32'(busy), 0);
      end
      irq_req = 0;

      // R1 R4 R5 R6 accepted maskable entry
      exp_entry(8'h21, 1, 32'hCAFE_1234, 16'h0008);
      fire_irq(8'h21, 0);
      // R9 NMI held mid-sequence must not restart
      irq_nmi = 1; insn_done = 1;
      repeat (3) @(negedge clk);
      irq_nmi = 0; insn_done = 0;
      drain("R6");

      // R8 return restores the saved state
      sp_in = 32'h0000_0DF4;
      push_ev(K_RD, 32'h0DF4, 0, 0, 0, "R8");
      push_ev(K_RD, 32'h0DF8, 0, 0, 0, "R8");
      push_ev(K_RD, 32'h0DFC, 0, 0, 0, "R8");
      push_ev(K_LD, 32'h0000_8000, 32'h0000_0020, 32'h0000_0246, 32'h0000_0E00, "R8");
      iret_req = 1; insn_done = 1;
      @(negedge clk);
      iret_req = 0; insn_done = 0;
      drain("R8");

      // R2 NMI beats a maskable request, enable clear
      flags_in = 32'h0000_0002; cs_in = 16'h0030; ip_in = 32'h0000_9ABC; sp_in = 32'h0000_0F00;
      exp_entry(2, 1, 32'h0001_0200, 16'h0010);
      irq_vec = 8'h33; irq_req = 1; irq_nmi = 1; insn_done = 1;
      @(negedge clk);
      irq_req = 0; irq_nmi = 0; insn_done = 0;
      drain("R2");

      // R4 highest vector
      flags_in = 32'h0000_0A02; cs_in = 16'h0040; ip_in = 32'h0000_1000; sp_in = 32'h0000_0E80;
      exp_entry(8'hFF, 1, 32'hFFFF_0004, 16'h0018);
      fire_irq(8'hFF, 0);
      drain("R4");

      // R7 malformed gates
      flags_in = 32'h0000_0202; sp_in = 32'h0000_0E40;
      for (int v = 8'h40; v <= 8'h43; v++) begin
         exp_entry(v, 0, 0, 0);
         fire_irq(8'(v), 0);
         drain("R7");
      end

      repeat (3) @(negedge clk);
      check(busy == 0 && q.size() == 0, "R9", "idle at end", 32'(busy), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule